// File: doc/BRIEF.md
# TFT Panel Timing Generator

This block produces the strobes that pace a TFT colour panel: a pixel-clock enable, a horizontal sync pulse, a vertical sync pulse and a data-valid (output enable) strobe. Each base-clock cycle is one pixel-clock period. Horizontal and vertical intervals come from configuration inputs: the number of pixels per line, the number of displayed lines, the horizontal sync length, the two horizontal gaps around the active pixels, the vertical sync length and the two vertical gaps. Sync and data-valid strobes each have their own polarity. The pixel clock can run freely, or it can be held off during vertical sync or whenever data-valid is idle.

A pixel source sits beside the block. One cycle before each data-valid clock, the block raises a request strobe and gives the column and row of the pixel it needs. The source then registers that pixel onto the panel data bus so it lines up with data-valid. The configuration is captured only at the start of a frame, so a frame never mixes two timings. Dropping the enable input clears every counter and parks every output at its idle level.

Top module: `tft_panel_timer`

## Requirements
- R1: The horizontal sync pulse lasts `cfg_hs_len`+1 clocks and repeats once per line period on every line of the frame, including sync and gap lines.
- R2: The gap from the end of horizontal sync to the first data-valid clock is `cfg_h_back`+3 clocks. Data-valid then lasts `cfg_width` clocks. The gap from its end to the next horizontal sync is `cfg_h_front`+1 clocks. The line period L is the sum of these four intervals.
- R3: Vertical sync lasts `cfg_vs_len` line periods (a value of 0 counts as 1). Its leading edge begins each frame.
- R4: From the end of vertical sync to the first data-valid clock of the frame is `cfg_v_back`·L+1 clocks.
- R5: From the end of the last data-valid clock of a frame to the next vertical sync is `cfg_v_front`·L + (L − `cfg_width`) − 1 clocks.
- R6: Data-valid appears only on the `cfg_height` displayed lines, so a frame has `cfg_width`·`cfg_height` data-valid clocks. A height of 0 gives none.
- R7: Each of `hsync`, `vsync` and `oe` is active high when its polarity input is 1 and active low when it is 0.
- R8: `cfg_clk_mode` sets the `sclk_en` behaviour. With 0 or 3, `sclk_en` stays at 1. With 1, `sclk_en` is 0 exactly while vertical sync is active. With 2, `sclk_en` is 0 exactly while data-valid is idle.
- R9: `px_req` is high exactly one clock before each data-valid clock. While it is high, `px_x` counts the pixel index 0..`cfg_width`−1 and `px_y` counts the displayed-line index 0..`cfg_height`−1. Both read 0 when `px_req` is low.
- R10: The configuration inputs, polarities and clock mode included, are sampled only when a new frame begins. A change made mid-frame takes effect from the next frame.
- R11: While `en` is low, one clock later `sclk_en`, `px_req`, `px_x` and `px_y` are 0 and each strobe sits at its idle level. The first rising edge with `en` high starts a frame. `px_req`/`px_x`/`px_y` trail that frame's internal position by one clock; `hsync`/`vsync`/`oe`/`sclk_en` trail it by two.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Base clock, one pixel-clock period per cycle |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Run enable; low clears counters and idles outputs |
| cfg_width | input | XW | Active pixels per line |
| cfg_height | input | YW | Displayed lines per frame |
| cfg_hs_len | input | HW | Horizontal sync length minus one |
| cfg_h_front | input | HW | Data-valid end to sync gap minus one |
| cfg_h_back | input | HW | Sync end to data-valid gap minus three |
| cfg_vs_len | input | VW | Vertical sync length in lines |
| cfg_v_front | input | VW | Lines between last displayed line and vertical sync |
| cfg_v_back | input | VW | Lines between vertical sync and first displayed line |
| cfg_hs_pol | input | 1 | 1: hsync active high |
| cfg_vs_pol | input | 1 | 1: vsync active high |
| cfg_oe_pol | input | 1 | 1: oe active high |
| cfg_clk_mode | input | 2 | Pixel-clock gating mode |
| sclk_en | output | 1 | Pixel clock enable |
| hsync | output | 1 | Horizontal sync strobe |
| vsync | output | 1 | Vertical sync strobe |
| oe | output | 1 | Data-valid strobe |
| px_req | output | 1 | Pixel request, one clock ahead of data-valid |
| px_x | output | XW | Requested pixel column |
| px_y | output | YW | Requested displayed-line row |

## Verification
A wrong slot position shifts the horizontal sync or data-valid edge within the same line, so the error shows within one line period. A wrong vertical region or row count moves vertical sync or the first displayed line. That shows within one frame as a wrong sync length, a wrong gap, or a wrong count of data-valid clocks. A shadow register loaded at the wrong time shows up as a timing or polarity change in the middle of a frame, in the first frame after the inputs change.

// File: rtl/tftp_pkg.sv
package tftp_pkg;

  typedef enum logic [1:0] {
    RG_SYNC  = 2'd0,
    RG_BACK  = 2'd1,
    RG_SHOW  = 2'd2,
    RG_FRONT = 2'd3
  } vreg_e;

  localparam logic [1:0] CKM_STOP_VS   = 2'd1;
  localparam logic [1:0] CKM_STOP_IDLE = 2'd2;

  // Region that follows the current one; zero-length regions are skipped.
  function automatic vreg_e vreg_next(input vreg_e cur, input logic has_back,
                                      input logic has_show, input logic has_front);
    vreg_e n;
    n = RG_SYNC;
    case (cur)
      RG_SYNC:  n = has_back ? RG_BACK : (has_show ? RG_SHOW : (has_front ? RG_FRONT : RG_SYNC));
      RG_BACK:  n = has_show ? RG_SHOW : (has_front ? RG_FRONT : RG_SYNC);
      RG_SHOW:  n = has_front ? RG_FRONT : RG_SYNC;
      default:  n = RG_SYNC;
    endcase
    return n;
  endfunction

endpackage

// File: rtl/tftp_cfg_shadow.sv
module tftp_cfg_shadow #(
  parameter int XW = 10,
  parameter int YW = 10,
  parameter int HW = 8,
  parameter int VW = 6
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [XW-1:0] in_width,
  input  logic [YW-1:0] in_height,
  input  logic [HW-1:0] in_hs_len,
  input  logic [HW-1:0] in_h_front,
  input  logic [HW-1:0] in_h_back,
  input  logic [VW-1:0] in_vs_len,
  input  logic [VW-1:0] in_v_front,
  input  logic [VW-1:0] in_v_back,
  input  logic [2:0]    in_pol,
  input  logic [1:0]    in_mode,
  output logic [XW-1:0] sh_width,
  output logic [YW-1:0] sh_height,
  output logic [HW-1:0] sh_hs_len,
  output logic [HW-1:0] sh_h_front,
  output logic [HW-1:0] sh_h_back,
  output logic [VW-1:0] sh_vs_len,
  output logic [VW-1:0] sh_v_front,
  output logic [VW-1:0] sh_v_back,
  output logic [2:0]    sh_pol,
  output logic [1:0]    sh_mode
);

  always_ff @(posedge clk) begin
    if (rst) begin
      sh_width   <= '0;
      sh_height  <= '0;
      sh_hs_len  <= '0;
      sh_h_front <= '0;
      sh_h_back  <= '0;
      sh_vs_len  <= '0;
      sh_v_front <= '0;
      sh_v_back  <= '0;
      sh_pol     <= '0;
      sh_mode    <= '0;
    end else if (load) begin
      sh_width   <= in_width;
      sh_height  <= in_height;
      sh_hs_len  <= in_hs_len;
      sh_h_front <= in_h_front;
      sh_h_back  <= in_h_back;
      sh_vs_len  <= in_vs_len;
      sh_v_front <= in_v_front;
      sh_v_back  <= in_v_back;
      sh_pol     <= in_pol;
      sh_mode    <= in_mode;
    end
  end

endmodule

// File: rtl/tftp_hpos.sv
module tftp_hpos #(
  parameter int XW = 10,
  parameter int HW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          run,
  input  logic [XW-1:0] width,
  input  logic [HW-1:0] hs_len,
  input  logic [HW-1:0] h_front,
  input  logic [HW-1:0] h_back,
  output logic          slot_end,
  output logic          hs_win,
  output logic          px_win,
  output logic [XW-1:0] px_col
);

  localparam int SW = ((XW > HW) ? XW : HW) + 3;
  localparam logic [SW-1:0] K1 = SW'(1);
  localparam logic [SW-1:0] K3 = SW'(3);

  // Slot coordinates: position 0 is the final back-gap clock, 1..width are
  // the active pixels, then the front gap, the sync pulse and the rest of
  // the back gap.
  logic [SW-1:0] pos;
  logic [SW-1:0] xm, gap_f, sync_w, gap_b;
  logic [SW-1:0] hs_lo, hs_hi, slot_len;

  assign xm       = SW'(width);
  assign gap_f    = SW'(h_front) + K1;
  assign sync_w   = SW'(hs_len) + K1;
  assign gap_b    = SW'(h_back) + K3;
  assign hs_lo    = K1 + xm + gap_f;
  assign hs_hi    = hs_lo + sync_w;
  assign slot_len = xm + gap_f + sync_w + gap_b;

  assign slot_end = (pos == slot_len - K1);
  assign hs_win   = (pos >= hs_lo) && (pos < hs_hi);
  assign px_win   = (pos != '0) && (pos <= xm);
  assign px_col   = XW'(pos - K1);

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      pos <= '0;
    end else if (slot_end) begin
      pos <= '0;
    end else begin
      pos <= pos + K1;
    end
  end

endmodule

// File: rtl/tftp_vline.sv
module tftp_vline
  import tftp_pkg::*;
#(
  parameter int YW = 10,
  parameter int VW = 6
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          run,
  input  logic          slot_end,
  input  logic [YW-1:0] height,
  input  logic [VW-1:0] vs_len,
  input  logic [VW-1:0] v_front,
  input  logic [VW-1:0] v_back,
  output vreg_e         region,
  output logic [YW-1:0] row,
  output logic          frame_end
);

  localparam int LW = ((YW > VW) ? YW : VW) + 1;
  localparam logic [LW-1:0] L1 = LW'(1);

  logic [LW-1:0] cnt;
  logic [LW-1:0] sync_n, cur_n;
  logic          last_row;
  vreg_e         nxt;

  assign sync_n = (vs_len == '0) ? L1 : LW'(vs_len);

  always_comb begin
    case (region)
      RG_SYNC:  cur_n = sync_n;
      RG_BACK:  cur_n = LW'(v_back);
      RG_SHOW:  cur_n = LW'(height);
      default:  cur_n = LW'(v_front);
    endcase
  end

  assign nxt       = vreg_next(region, v_back != '0, height != '0, v_front != '0);
  assign last_row  = (cnt == cur_n - L1);
  assign frame_end = run && slot_end && last_row && (nxt == RG_SYNC);
  assign row       = YW'(cnt);

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      region <= RG_SYNC;
      cnt    <= '0;
    end else if (slot_end) begin
      if (last_row) begin
        region <= nxt;
        cnt    <= '0;
      end else begin
        cnt <= cnt + L1;
      end
    end
  end

endmodule

// File: rtl/tftp_outpipe.sv
module tftp_outpipe
  import tftp_pkg::*;
#(
  parameter int XW = 10,
  parameter int YW = 10
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          run,
  input  logic          hs_win,
  input  logic          vs_win,
  input  logic          oe_win,
  input  logic [XW-1:0] col,
  input  logic [YW-1:0] row,
  input  logic [2:0]    pol,
  input  logic [1:0]    mode,
  output logic          px_req,
  output logic [XW-1:0] px_x,
  output logic [YW-1:0] px_y,
  output logic          hsync,
  output logic          vsync,
  output logic          oe,
  output logic          sclk_en,
  output logic          hs_on,
  output logic          vs_on,
  output logic          oe_on,
  output logic [1:0]    mode_q
);

  // Stage one: raw strobes plus the polarity and mode of the same slot.
  logic       s1_hs, s1_vs;
  logic [2:0] s1_pol;
  logic [1:0] s1_mode;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_hs   <= 1'b0;
      s1_vs   <= 1'b0;
      px_req  <= 1'b0;
      px_x    <= '0;
      px_y    <= '0;
      s1_pol  <= '0;
      s1_mode <= '0;
    end else begin
      s1_pol  <= pol;
      s1_mode <= mode;
      if (!run) begin
        s1_hs  <= 1'b0;
        s1_vs  <= 1'b0;
        px_req <= 1'b0;
        px_x   <= '0;
        px_y   <= '0;
      end else begin
        s1_hs  <= hs_win;
        s1_vs  <= vs_win;
        px_req <= oe_win;
        px_x   <= oe_win ? col : '0;
        px_y   <= oe_win ? row : '0;
      end
    end
  end

  // Stage two: polarity and clock gating applied, registered to the pins.
  always_ff @(posedge clk) begin
    if (rst) begin
      hs_on   <= 1'b0;
      vs_on   <= 1'b0;
      oe_on   <= 1'b0;
      hsync   <= 1'b0;
      vsync   <= 1'b0;
      oe      <= 1'b0;
      sclk_en <= 1'b0;
      mode_q  <= '0;
    end else if (!run) begin
      hs_on   <= 1'b0;
      vs_on   <= 1'b0;
      oe_on   <= 1'b0;
      hsync   <= ~s1_pol[2];
      vsync   <= ~s1_pol[1];
      oe      <= ~s1_pol[0];
      sclk_en <= 1'b0;
      mode_q  <= s1_mode;
    end else begin
      hs_on   <= s1_hs;
      vs_on   <= s1_vs;
      oe_on   <= px_req;
      hsync   <= s1_pol[2] ? s1_hs  : ~s1_hs;
      vsync   <= s1_pol[1] ? s1_vs  : ~s1_vs;
      oe      <= s1_pol[0] ? px_req : ~px_req;
      mode_q  <= s1_mode;
      case (s1_mode)
        CKM_STOP_VS:   sclk_en <= ~s1_vs;
        CKM_STOP_IDLE: sclk_en <= px_req;
        default:       sclk_en <= 1'b1;
      endcase
    end
  end

endmodule

// File: rtl/tft_panel_timer.sv
module tft_panel_timer
  import tftp_pkg::*;
#(
  parameter int XW = 10,
  parameter int YW = 10,
  parameter int HW = 8,
  parameter int VW = 6
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  logic [XW-1:0] cfg_width,
  input  logic [YW-1:0] cfg_height,
  input  logic [HW-1:0] cfg_hs_len,
  input  logic [HW-1:0] cfg_h_front,
  input  logic [HW-1:0] cfg_h_back,
  input  logic [VW-1:0] cfg_vs_len,
  input  logic [VW-1:0] cfg_v_front,
  input  logic [VW-1:0] cfg_v_back,
  input  logic          cfg_hs_pol,
  input  logic          cfg_vs_pol,
  input  logic          cfg_oe_pol,
  input  logic [1:0]    cfg_clk_mode,
  output logic          sclk_en,
  output logic          hsync,
  output logic          vsync,
  output logic          oe,
  output logic          px_req,
  output logic [XW-1:0] px_x,
  output logic [YW-1:0] px_y
);

  logic [XW-1:0] sh_width;
  logic [YW-1:0] sh_height;
  logic [HW-1:0] sh_hs_len, sh_h_front, sh_h_back;
  logic [VW-1:0] sh_vs_len, sh_v_front, sh_v_back;
  logic [2:0]    sh_pol;
  logic [1:0]    sh_mode;

  logic          slot_end, hs_win, px_win, frame_end, shadow_load;
  logic [XW-1:0] px_col;
  logic [YW-1:0] row;
  vreg_e         region;
  logic          hs_on, vs_on, oe_on;
  logic [1:0]    mode_q;

  assign shadow_load = !en || frame_end;

  tftp_cfg_shadow #(.XW(XW), .YW(YW), .HW(HW), .VW(VW)) u_shadow (
    .clk(clk), .rst(rst), .load(shadow_load),
    .in_width(cfg_width), .in_height(cfg_height),
    .in_hs_len(cfg_hs_len), .in_h_front(cfg_h_front), .in_h_back(cfg_h_back),
    .in_vs_len(cfg_vs_len), .in_v_front(cfg_v_front), .in_v_back(cfg_v_back),
    .in_pol({cfg_hs_pol, cfg_vs_pol, cfg_oe_pol}), .in_mode(cfg_clk_mode),
    .sh_width(sh_width), .sh_height(sh_height),
    .sh_hs_len(sh_hs_len), .sh_h_front(sh_h_front), .sh_h_back(sh_h_back),
    .sh_vs_len(sh_vs_len), .sh_v_front(sh_v_front), .sh_v_back(sh_v_back),
    .sh_pol(sh_pol), .sh_mode(sh_mode)
  );

  tftp_hpos #(.XW(XW), .HW(HW)) u_hpos (
    .clk(clk), .rst(rst), .run(en),
    .width(sh_width), .hs_len(sh_hs_len), .h_front(sh_h_front), .h_back(sh_h_back),
    .slot_end(slot_end), .hs_win(hs_win), .px_win(px_win), .px_col(px_col)
  );

  tftp_vline #(.YW(YW), .VW(VW)) u_vline (
    .clk(clk), .rst(rst), .run(en), .slot_end(slot_end),
    .height(sh_height), .vs_len(sh_vs_len), .v_front(sh_v_front), .v_back(sh_v_back),
    .region(region), .row(row), .frame_end(frame_end)
  );

  tftp_outpipe #(.XW(XW), .YW(YW)) u_out (
    .clk(clk), .rst(rst), .run(en),
    .hs_win(hs_win), .vs_win(region == RG_SYNC),
    .oe_win(px_win && (region == RG_SHOW)),
    .col(px_col), .row(row), .pol(sh_pol), .mode(sh_mode),
    .px_req(px_req), .px_x(px_x), .px_y(px_y),
    .hsync(hsync), .vsync(vsync), .oe(oe), .sclk_en(sclk_en),
    .hs_on(hs_on), .vs_on(vs_on), .oe_on(oe_on), .mode_q(mode_q)
  );

endmodule

// File: rtl/tftp_chk.sv
module tftp_chk #(
  parameter int XW = 10
) (
  input logic          clk,
  input logic          rst,
  input logic          en,
  input logic          px_req,
  input logic [XW-1:0] px_x,
  input logic          sclk_en,
  input logic          hs_on,
  input logic          vs_on,
  input logic          oe_on,
  input logic [1:0]    mode_q
);

  // R11
  quiet_when_off_chk: assert property (@(posedge clk) disable iff (rst)
    !en |=> (!oe_on && !hs_on && !vs_on && !px_req && !sclk_en));

  // R9
  req_leads_oe_chk: assert property (@(posedge clk) disable iff (rst)
    (en && px_req) |=> oe_on);

  // R9
  col_step_chk: assert property (@(posedge clk) disable iff (rst)
    (px_req && $past(px_req)) |-> (px_x == XW'($past(px_x) + 1'b1)));

  // R8
  idle_gate_chk: assert property (@(posedge clk) disable iff (rst)
    (mode_q == 2'd2) |-> (sclk_en == oe_on));

  // R6
  oe_clear_of_sync_chk: assert property (@(posedge clk) disable iff (rst)
    oe_on |-> (!hs_on && !vs_on));

  // R2
  front_gap_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(oe_on) |-> !hs_on);

endmodule

bind tft_panel_timer tftp_chk #(.XW(XW)) u_chk (
  .clk(clk), .rst(rst), .en(en), .px_req(px_req), .px_x(px_x),
  .sclk_en(sclk_en), .hs_on(hs_on), .vs_on(vs_on), .oe_on(oe_on), .mode_q(mode_q)
);

// File: tb/sim_tft_panel_timer.sv
module sim_tft_panel_timer;

  localparam int XW = 10, YW = 10, HW = 8, VW = 6;

  typedef struct {
    int xm, ht, hf, hb, vt, vf, vb, ln, phs, pvs, poe, md;
  } cfg_t;

  logic clk = 1'b0, rst = 1'b1, en = 1'b0;
  logic [XW-1:0] cfg_width = '0;
  logic [YW-1:0] cfg_height = '0;
  logic [HW-1:0] cfg_hs_len = '0, cfg_h_front = '0, cfg_h_back = '0;
  logic [VW-1:0] cfg_vs_len = '0, cfg_v_front = '0, cfg_v_back = '0;
  logic cfg_hs_pol = 1'b1, cfg_vs_pol = 1'b1, cfg_oe_pol = 1'b1;
  logic [1:0] cfg_clk_mode = '0;
  logic sclk_en, hsync, vsync, oe, px_req;
  logic [XW-1:0] px_x;
  logic [YW-1:0] px_y;

  int checks = 0, fails = 0;
  bit done = 0;

  always #10 clk = ~clk;

  tft_panel_timer #(.XW(XW), .YW(YW), .HW(HW), .VW(VW)) u0 (
    .clk(clk), .rst(rst), .en(en),
    .cfg_width(cfg_width), .cfg_height(cfg_height),
    .cfg_hs_len(cfg_hs_len), .cfg_h_front(cfg_h_front), .cfg_h_back(cfg_h_back),
    .cfg_vs_len(cfg_vs_len), .cfg_v_front(cfg_v_front), .cfg_v_back(cfg_v_back),
    .cfg_hs_pol(cfg_hs_pol), .cfg_vs_pol(cfg_vs_pol), .cfg_oe_pol(cfg_oe_pol),
    .cfg_clk_mode(cfg_clk_mode),
    .sclk_en(sclk_en), .hsync(hsync), .vsync(vsync), .oe(oe),
    .px_req(px_req), .px_x(px_x), .px_y(px_y)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s act=%0d exp=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic apply(input cfg_t c);
    cfg_width    = XW'(c.xm);
    cfg_height   = YW'(c.ln);
    cfg_hs_len   = HW'(c.ht);
    cfg_h_front  = HW'(c.hf);
    cfg_h_back   = HW'(c.hb);
    cfg_vs_len   = VW'(c.vt);
    cfg_v_front  = VW'(c.vf);
    cfg_v_back   = VW'(c.vb);
    cfg_hs_pol   = c.phs[0];
    cfg_vs_pol   = c.pvs[0];
    cfg_oe_pol   = c.poe[0];
    cfg_clk_mode = 2'(c.md);
  endtask

  function automatic int llen(input cfg_t c);
    return c.xm + (c.hf + 1) + (c.ht + 1) + (c.hb + 3);
  endfunction

  function automatic int vsn(input cfg_t c);
    return (c.vt == 0) ? 1 : c.vt;
  endfunction

  function automatic int flen(input cfg_t c);
    return llen(c) * (vsn(c) + c.vb + c.ln + c.vf);
  endfunction

  // Expected raw strobes at frame-relative cycle k for configuration c.
  task automatic model(input cfg_t c, input int k, output int hs, output int vs,
                       output int oen, output int x, output int y);
    int L, kk, pos, s, hlo;
    L   = llen(c);
    kk  = k % flen(c);
    pos = kk % L;
    s   = kk / L;
    hlo = 1 + c.xm + c.hf + 1;
    hs  = (pos >= hlo && pos < hlo + c.ht + 1) ? 1 : 0;
    vs  = (s < vsn(c)) ? 1 : 0;
    oen = (s >= vsn(c) + c.vb && s < vsn(c) + c.vb + c.ln && pos >= 1 && pos <= c.xm) ? 1 : 0;
    x   = oen ? pos - 1 : 0;
    y   = oen ? s - vsn(c) - c.vb : 0;
  endtask

  task automatic at_state(input cfg_t a, input cfg_t b, input int k, output cfg_t c,
                          output int hs, output int vs, output int oen,
                          output int x, output int y);
    if (k < 0) begin
      c = a; hs = 0; vs = 0; oen = 0; x = 0; y = 0;
    end else if (k < flen(a)) begin
      c = a; model(a, k, hs, vs, oen, x, y);
    end else begin
      c = b; model(b, k - flen(a), hs, vs, oen, x, y);
    end
  endtask

  task automatic check_idle(input cfg_t c, input string tg);
    check({"R11 idle hsync", tg}, int'(hsync), c.phs ? 0 : 1);
    check({"R11 idle vsync", tg}, int'(vsync), c.pvs ? 0 : 1);
    check({"R11 idle oe", tg}, int'(oe), c.poe ? 0 : 1);
    check({"R11 idle sclk_en", tg}, int'(sclk_en), 0);
    check({"R11 idle px_req", tg}, int'(px_req), 0);
    check({"R11 idle px_x/px_y", tg}, int'(px_x) + int'(px_y), 0);
  endtask

  task automatic run(input cfg_t a, input cfg_t b, input int sw_at, input int ncyc,
                     input string tg);
    cfg_t c1, c2;
    int h1, v1, o1, x1, y1, h2, v2, o2, x2, y2, ck;
    int L, reqs, t_vsend, t_oeend;
    bit pv, po, nv, no;
    en = 1'b0;
    apply(a);
    repeat (3) @(negedge clk);
    check_idle(a, tg);
    en = 1'b1;
    L = llen(a); reqs = 0; t_vsend = -1; t_oeend = -1; pv = 0; po = 0;
    for (int j = 1; j <= ncyc; j++) begin
      @(negedge clk);
      at_state(a, b, j - 1, c1, h1, v1, o1, x1, y1);
      at_state(a, b, j - 2, c2, h2, v2, o2, x2, y2);
      check({"R9 px_req", tg}, int'(px_req), o1);
      check({"R9 px_x", tg}, int'(px_x), x1);
      check({"R9 px_y", tg}, int'(px_y), y1);
      check({"R1 R7 hsync", tg}, int'(hsync), c2.phs ? h2 : 1 - h2);
      check({"R3 R7 vsync", tg}, int'(vsync), c2.pvs ? v2 : 1 - v2);
      check({"R2 R6 R7 oe", tg}, int'(oe), c2.poe ? o2 : 1 - o2);
      ck = (c2.md == 1) ? 1 - v2 : ((c2.md == 2) ? o2 : 1);
      check({"R8 sclk_en", tg}, int'(sclk_en), ck);
      if (j - 1 < flen(a) && px_req) reqs++;
      if (sw_at == 0) begin
        nv = (vsync == a.pvs[0]);
        no = (oe == a.poe[0]);
        if (pv && !nv) t_vsend = j;
        if (!po && no && t_vsend >= 0) begin
          check("R4 vsync end to first oe", j - t_vsend, a.vb * L + 1);
          t_vsend = -1;
        end
        if (po && !no) t_oeend = j;
        if (!pv && nv && t_oeend >= 0) begin
          check("R5 last oe to vsync", j - t_oeend, a.vf * L + (L - a.xm) - 1);
          t_oeend = -1;
        end
        pv = nv; po = no;
      end
      if (j == sw_at) apply(b);
    end
    if (sw_at == 0) check("R6 data-valid clocks per frame", reqs, a.xm * a.ln);
    en = 1'b0;
    @(negedge clk);
    check_idle(b, tg);
  endtask

  function automatic cfg_t mkcfg(input int i);
    cfg_t c;
    int r;
    r = i / 3;
    c.xm  = (i % 3 == 2) ? 3 : i % 3;
    c.ht  = (r & 1) * 2;
    c.hf  = (r >> 1) & 1;
    c.hb  = ((r >> 2) & 1) * 2;
    c.vt  = ((r >> 3) & 1) * 2;
    c.vb  = (r >> 4) & 1;
    c.ln  = ((r >> 5) & 1) * 2;
    c.vf  = (r >> 6) & 1;
    c.phs = i & 1;
    c.pvs = (i >> 1) & 1;
    c.poe = (i / 5) & 1;
    c.md  = (i / 7) % 4;
    return c;
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    // Reset state
    check("R11 reset hsync", int'(hsync), 0);
    check("R11 reset vsync", int'(vsync), 0);
    check("R11 reset oe", int'(oe), 0);
    check("R11 reset sclk_en", int'(sclk_en), 0);
    check("R11 reset px_req", int'(px_req), 0);
    rst = 1'b0;
    @(negedge clk);
    for (int i = 0; i < 384; i++) begin
      cfg_t c;
      c = mkcfg(i);
      run(c, c, 0, 2 * flen(c) + 4, " sweep");
    end
    // Mid-frame configuration changes take effect at the next frame: R10
    for (int s = 0; s < 6; s++) begin
      cfg_t a, b;
      a = mkcfg((s * 61 + 5) % 384);
      b = mkcfg((s * 97 + 50) % 384);
      a.ln = 2; b.xm = a.xm + 1;
      run(a, b, flen(a) / 2, flen(a) + 2 * flen(b) + 4, " R10");
    end
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL R11 watchdog act=%0d exp=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule